// File: doc/BRIEF.md
# Serial Port Handshake Control and Status Register

This block sits beside a serial port's data path. It holds the four handshake outputs of the port: data-terminal-ready, request-to-send and two general-purpose lines. It also watches the four handshake inputs: clear-to-send, data-set-ready, ring indicator and carrier detect. Each input passes through a two-flop synchronizer. The block reports the current input levels in a status word. For each input it keeps a sticky change flag, which is set on any transition in either direction and cleared when software reads the status word. The OR of the change flags goes to the port's interrupt logic as a single change indication.

Setting a mode bit in the control word moves the block into local loopback. The status levels then come from the block's own control outputs instead of the external pins, and the external data-terminal-ready and request-to-send pins are forced low. A small two-state mode machine tracks loopback.

- States: `MODE_DIRECT` (the status levels follow the synchronized pins) and `MODE_LOOP` (the status levels follow the control outputs).
- `MODE_DIRECT` to `MODE_LOOP`: a control write with bit 4 set.
- `MODE_LOOP` to `MODE_DIRECT`: a control write with bit 4 clear.
- Any other write keeps the current state.

The address decoder sits outside this block and produces plain write and read strobes.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the control word reads 0x00, all four output pins are low, the mode is direct, the status change bits are 0 and `chg_irq` is low.
- R2: A control write takes effect on the next clock edge. Written bit 0 drives `pin_dtr`, bit 1 drives `pin_rts`, bit 2 drives `pin_gp1`, bit 3 drives `pin_gp2` and bit 4 selects loopback. `ctrl_rdata` returns bits 4..0 as written.
- R3: Status bits 4, 5, 6 and 7 give the levels of CTS, DSR, RI and DCD, reading 1 when the line is high. A pin change is first visible on the third rising edge after it. It is not visible after the second edge.
- R4: Status bits 0, 1, 2 and 3 are the change flags for CTS, DSR, RI and DCD. A flag is set on the same edge on which its level bit changes, for a rising change and for a falling change alike.
- R5: A clock edge on which `stat_rd` is high clears all four change flags.
- R6: If a level changes on the same edge as a status read, its change flag is set after that edge.
- R7: `chg_irq` is high exactly when at least one change flag is set.
- R8: In loopback, CTS takes the level of control bit 1, DSR bit 0, RI bit 2 and DCD bit 3. Each takes effect one edge after the control register changes. External input pins have no effect on the status word.
- R9: In loopback `pin_dtr` and `pin_rts` are held low, while `pin_gp1` and `pin_gp2` still follow control bits 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | LINES+1 | Control word write data |
| ctrl_rdata | output | LINES+1 | Control word read-back |
| stat_rd | input | 1 | Status read strobe; clears change flags |
| stat_rdata | output | 2*LINES | Status word: levels in the upper half, change flags in the lower half |
| pin_cts | input | 1 | External clear-to-send, asynchronous |
| pin_dsr | input | 1 | External data-set-ready, asynchronous |
| pin_ri | input | 1 | External ring indicator, asynchronous |
| pin_dcd | input | 1 | External carrier detect, asynchronous |
| pin_dtr | output | 1 | Data-terminal-ready output |
| pin_rts | output | 1 | Request-to-send output |
| pin_gp1 | output | 1 | General-purpose output 1 |
| pin_gp2 | output | 1 | General-purpose output 2 |
| chg_irq | output | 1 | Handshake-change indication to interrupt logic |

## Verification
A wrong previous-level register shows up as a change flag that is set with no pin activity, or as one that is missing after a transition. Either appears on `stat_rdata` and `chg_irq` on the edge after the level update. A mode machine stuck in the wrong state shows within one edge of a control write in two places: the forced-low pins and the source of the status levels. A clear with the wrong priority loses a flag that was set on the read edge, which the very next read exposes.

// File: rtl/modem_ctl_stat_pkg.sv
package modem_ctl_stat_pkg;

    typedef enum logic {
        MODE_DIRECT = 1'b0,
        MODE_LOOP   = 1'b1
    } mcs_mode_e;

    // control bit positions
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_GP1  = 2;
    localparam int CB_GP2  = 3;

    // handshake line positions inside a level vector
    localparam int HL_CTS  = 0;
    localparam int HL_DSR  = 1;
    localparam int HL_RI   = 2;
    localparam int HL_DCD  = 3;

endpackage

// File: rtl/mcs_sync.sv
module mcs_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/mcs_ctrl.sv
module mcs_ctrl
    import modem_ctl_stat_pkg::*;
#(
    parameter int LINES = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr,
    input  logic [LINES:0] wdata,
    output logic [LINES-1:0] ctrl_q,
    output logic           loop_on
);
    localparam int LB = LINES;

    mcs_mode_e state, state_nx;

    // state register and control bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= MODE_DIRECT;
            ctrl_q <= '0;
        end else begin
            state <= state_nx;
            if (wr) ctrl_q <= wdata[LINES-1:0];
        end
    end

    // transitions and outputs
    always_comb begin
        state_nx = state;
        loop_on  = 1'b0;
        unique case (state)
            MODE_DIRECT: begin
                loop_on = 1'b0;
                if (wr && wdata[LB]) state_nx = MODE_LOOP;
            end
            MODE_LOOP: begin
                loop_on = 1'b1;
                if (wr && !wdata[LB]) state_nx = MODE_DIRECT;
            end
            default: state_nx = MODE_DIRECT;
        endcase
    end
endmodule

// File: rtl/mcs_delta.sv
module mcs_delta #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         clr,
    output logic [W-1:0] level_q,
    output logic [W-1:0] delta_q
);
    logic [W-1:0] moved;
    assign moved = lvl ^ level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
            delta_q <= '0;
        end else begin
            level_q <= lvl;
            // a fresh change wins over the read clear
            delta_q <= (clr ? '0 : delta_q) | moved;
        end
    end
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
    import modem_ctl_stat_pkg::*;
#(
    parameter int LINES       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [LINES:0]   ctrl_wdata,
    output logic [LINES:0]   ctrl_rdata,
    input  logic             stat_rd,
    output logic [2*LINES-1:0] stat_rdata,
    input  logic             pin_cts,
    input  logic             pin_dsr,
    input  logic             pin_ri,
    input  logic             pin_dcd,
    output logic             pin_dtr,
    output logic             pin_rts,
    output logic             pin_gp1,
    output logic             pin_gp2,
    output logic             chg_irq
);
    logic [LINES-1:0] ext_raw, ext_sync, lb_vec, lvl, level_q, delta_q, ctrl_q;
    logic             loop_on;

    always_comb begin
        ext_raw         = '0;
        ext_raw[HL_CTS] = pin_cts;
        ext_raw[HL_DSR] = pin_dsr;
        ext_raw[HL_RI]  = pin_ri;
        ext_raw[HL_DCD] = pin_dcd;
    end

    mcs_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ext_raw), .q(ext_sync)
    );

    mcs_ctrl #(.LINES(LINES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .loop_on(loop_on)
    );

    always_comb begin
        lb_vec         = '0;
        lb_vec[HL_CTS] = ctrl_q[CB_RTS];
        lb_vec[HL_DSR] = ctrl_q[CB_DTR];
        lb_vec[HL_RI]  = ctrl_q[CB_GP1];
        lb_vec[HL_DCD] = ctrl_q[CB_GP2];
    end

    assign lvl = loop_on ? lb_vec : ext_sync;

    mcs_delta #(.W(LINES)) u_delta (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .clr(stat_rd),
        .level_q(level_q), .delta_q(delta_q)
    );

    assign ctrl_rdata = {loop_on, ctrl_q};
    assign stat_rdata = {level_q, delta_q};
    assign chg_irq    = |delta_q;
    assign pin_dtr    = ctrl_q[CB_DTR] & ~loop_on;
    assign pin_rts    = ctrl_q[CB_RTS] & ~loop_on;
    assign pin_gp1    = ctrl_q[CB_GP1];
    assign pin_gp2    = ctrl_q[CB_GP2];
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk #(
    parameter int LINES = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               stat_rd,
    input logic [LINES:0]     ctrl_rdata,
    input logic [2*LINES-1:0] stat_rdata,
    input logic               pin_dtr,
    input logic               pin_rts,
    input logic               pin_gp1,
    input logic               pin_gp2,
    input logic               chg_irq
);
    localparam int LB = LINES;

    // R2
    direct_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rdata[LB] |-> (pin_dtr == ctrl_rdata[0] && pin_rts == ctrl_rdata[1]));

    // R9
    loop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[LB] |-> (!pin_dtr && !pin_rts && pin_gp1 == ctrl_rdata[2] && pin_gp2 == ctrl_rdata[3]));

    // R8
    loop_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[LB] && $past(ctrl_rdata[LB])) |->
        (stat_rdata[LINES+0] == $past(ctrl_rdata[1]) && stat_rdata[LINES+1] == $past(ctrl_rdata[0]) &&
         stat_rdata[LINES+2] == $past(ctrl_rdata[2]) && stat_rdata[LINES+3] == $past(ctrl_rdata[3])));

    // R4
    delta_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[2*LINES-1:LINES] != $past(stat_rdata[2*LINES-1:LINES])) |->
        ((stat_rdata[LINES-1:0] & (stat_rdata[2*LINES-1:LINES] ^ $past(stat_rdata[2*LINES-1:LINES])))
          == (stat_rdata[2*LINES-1:LINES] ^ $past(stat_rdata[2*LINES-1:LINES]))));

    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_rd) && stat_rdata[2*LINES-1:LINES] == $past(stat_rdata[2*LINES-1:LINES])) |->
        (stat_rdata[LINES-1:0] == '0));

    // R7
    irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg_irq == (stat_rdata[LINES-1:0] != '0));
endmodule

bind modem_ctl_stat modem_ctl_stat_chk #(.LINES(LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .ctrl_rdata(ctrl_rdata),
    .stat_rdata(stat_rdata), .pin_dtr(pin_dtr), .pin_rts(pin_rts),
    .pin_gp1(pin_gp1), .pin_gp2(pin_gp2), .chg_irq(chg_irq)
);

// File: tb/sim_modem_ctl_stat.sv
module sim_modem_ctl_stat;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_wr = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic [4:0] ctrl_rdata;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_rdata;
    logic       pin_cts = 1'b0, pin_dsr = 1'b0, pin_ri = 1'b0, pin_dcd = 1'b0;
    logic       pin_dtr, pin_rts, pin_gp1, pin_gp2, chg_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    modem_ctl_stat u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
        .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_ri(pin_ri), .pin_dcd(pin_dcd),
        .pin_dtr(pin_dtr), .pin_rts(pin_rts), .pin_gp1(pin_gp1), .pin_gp2(pin_gp2),
        .chg_irq(chg_irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // monitor: compares status word against scoreboard during a read
    always begin
        @(negedge clk);
        #5;
        if (stat_rd && exp_q.size() > 0) check(tag_q.pop_front(), stat_rdata, exp_q.pop_front());
    end

    // all tasks start and end at a falling edge
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(input logic [3:0] v); // bit0 CTS, 1 DSR, 2 RI, 3 DCD
        {pin_dcd, pin_ri, pin_dsr, pin_cts} = v;
        @(negedge clk);
    endtask

    task automatic ctrl_write(input logic [4:0] d);
        ctrl_wr = 1'b1;
        ctrl_wdata = d;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic rd_expect(input logic [7:0] e, input string req);
        stat_rd = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(req);
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic check_pins(input logic [3:0] e, input string req); // {gp2,gp1,rts,dtr}
        #5;
        check(req, {4'b0, pin_gp2, pin_gp1, pin_rts, pin_dtr}, {4'b0, e});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl", {3'b0, ctrl_rdata}, 8'h00);
        check_pins(4'b0000, "R1 pins");
        check("R1 irq", {7'b0, chg_irq}, 8'h00);
        idle(1);
        rd_expect(8'h00, "R1 status");

        // R3 latency on CTS rise
        set_pins(4'b0001);
        idle(1);
        check("R3 not yet visible", stat_rdata, 8'h00);
        idle(1);
        rd_expect(8'h11, "R3/R4 CTS rise");
        rd_expect(8'h10, "R5 cleared");
        check("R7 irq low after clear", {7'b0, chg_irq}, 8'h00);

        // R4 falling change
        set_pins(4'b0000);
        idle(2);
        check("R7 irq high", {7'b0, chg_irq}, 8'h01);
        rd_expect(8'h01, "R4 CTS fall");
        rd_expect(8'h00, "R5 cleared after fall");

        // several lines at once
        set_pins(4'b1010);
        idle(2);
        rd_expect(8'hAA, "R3/R4 DSR DCD rise");

        // R6 change on the read edge
        set_pins(4'b1011);
        idle(1);
        rd_expect(8'hA0, "R6 before change");
        rd_expect(8'hB1, "R6 change kept on read edge");
        rd_expect(8'hB0, "R5 cleared after R6");

        // R2 control outputs
        ctrl_write(5'h0F);
        check("R2 readback", {3'b0, ctrl_rdata}, 8'h0F);
        check_pins(4'b1111, "R2 all high");
        idle(1);
        ctrl_write(5'h05);
        check_pins(4'b0101, "R2 dtr gp1");

        // R8 / R9 loopback
        ctrl_write(5'h15);
        check("R2 loop readback", {3'b0, ctrl_rdata}, 8'h15);
        check_pins(4'b0100, "R9 dtr held low");
        idle(1);
        rd_expect(8'h6D, "R8 loop routing");
        set_pins(4'b0000);
        idle(3);
        rd_expect(8'h60, "R8 pins ignored");
        ctrl_write(5'h1A);
        check_pins(4'b1000, "R9 rts held low gp2 high");
        idle(1);
        rd_expect(8'h9F, "R8 loop all toggled");

        // leave loopback
        ctrl_write(5'h00);
        check_pins(4'b0000, "R2 outputs cleared");
        idle(1);
        rd_expect(8'h09, "R3 back to pins");
        check("R7 irq low", {7'b0, chg_irq}, 8'h00);

        idle(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule